// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block behaves as the storage side of a two-wire serial EEPROM. It samples the clock line and the incoming data line on the system clock and finds start and stop conditions. It counts bit cycles inside a transfer, shifts in the device byte, the word address and the write data, and drives an outgoing data level for acknowledges and read data. The bytes live in an internal array whose size is set by a parameter (128 bytes to 8 KiB, a power of two).

A static two-bit mode input picks the addressing variant. The legacy variant holds 128 bytes, and its first byte carries a 7-bit word address plus the direction bit. The one-byte variant sends a device byte and then one address byte, and three device-byte bits extend that address. The two-byte variant sends a device byte and then two address bytes. Writes move only the low address bits, so a burst stays inside its page. Sequential reads step through the whole address space.

Top module: `tws_eeprom`

## Requirements
- R1: After reset the block is idle (no transfer in progress, cycle count zero, word address zero) and `sdaOut` is 1.
- R2: With `sclIn` high, a falling `sdaIn` starts a transfer and clears the cycle count. A rising `sdaIn` ends it. While no transfer is in progress, `sdaOut` follows the last sampled `sdaIn`.
- R3: While a transfer is in progress, `sdaOut` is 0 in bit cycles 9, 18 and 27. The cycle count rises by one on every `sclIn` rising edge, and data is taken on the falling edge.
- R4: Mode encoding: 0 = legacy, 1 = one-byte address, 2 or 3 = two-byte address. In legacy mode, cycles 1–8 carry a 7-bit word address, MSB first, followed by the direction bit (1 = read). Cycles 10–17 carry a data byte MSB first, and the count then returns to 9.
- R5: A legacy write stores each byte at the current word address, then advances only the two lowest word-address bits (4-byte page).
- R6: A legacy read returns consecutive bytes, and the word address advances modulo 128 after each byte.
- R7: In the standard modes, cycles 1–8 carry a device byte whose bit 0 is the direction (1 = read). In mode 1 the next byte is the low address byte, and device-byte bits 3:1 become word-address bits 10:8.
- R8: In mode 2 the two bytes after the device byte form a 13-bit word address, high byte first. Storage is indexed by its low bits.
- R9: A standard-mode write stores each byte and then advances only the four lowest word-address bits (16-byte page).
- R10: A standard-mode read returns consecutive bytes, and the full 13-bit word address advances by one after each byte, wrapping to 0.
- R11: During a read, cycles 10–17 present the addressed byte MSB first (bit 17 − cycle).
- R12: When the direction bit selects a read, levels that the master drives in data cycles do not change storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Static addressing variant select |
| sclIn | input | 1 | Sampled serial clock level |
| sdaIn | input | 1 | Sampled serial data level from the master |
| sdaOut | output | 1 | Data level driven back toward the bus |

## Verification
A wrong cycle count or a missed start shows at `sdaOut` in the next acknowledge slot, at most nine bus clocks later, as a missing low level. A wrong word address or page-advance rule stays hidden until the following read transfer, where every returned byte is compared with a reference array. Reads are placed to cross 4-byte and 16-byte page ends and the top of the address space, so that wrap faults show in the first byte after the boundary. The low levels driven during a legacy read are followed by a second read of the same bytes, which exposes any write that happened in read direction.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int CYC_W = 6;
  localparam int ADDR_W = 13;

  typedef struct packed {
    logic shiftDev;
    logic shiftAddr;
    logic mergeDev;
    logic writeBit;
    logic pageAdv;
    logic seqAdv;
  } twsStrobe_t;
endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             isLegacy,
  input  logic             isOne,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             readFlag,
  input  logic [7:0]       rdByte,
  output twsStrobe_t       strobe,
  output logic             started,
  output logic             prevScl,
  output logic             prevSda,
  output logic [CYC_W-1:0] cycCnt,
  output logic             sdaOut
);
  logic startCond, stopCond, sclRise, sclFall;
  logic ackCyc, readWin, inData;
  logic [CYC_W-1:0] cycInc, cycNext, bitSel;
  logic seqWrap;

  assign startCond = sclIn && prevScl && prevSda && !sdaIn;
  assign stopCond  = sclIn && prevScl && !prevSda && sdaIn;
  assign sclRise   = started && !prevScl && sclIn;
  assign sclFall   = started && prevScl && !sclIn;

  assign ackCyc  = (cycCnt == 6'd9) || (cycCnt == 6'd18) || (cycCnt == 6'd27);
  assign readWin = (cycCnt >= 6'd10) && (cycCnt <= 6'd17);
  assign inData  = isOne ? (cycCnt > 6'd18) : (cycCnt > 6'd27);
  assign cycInc  = cycCnt + 6'd1;

  // counter wrap per variant, applied on the rising edge
  always_comb begin
    cycNext = cycInc;
    seqWrap = 1'b0;
    if (isLegacy) begin
      if (cycInc == 6'd18) begin
        cycNext = 6'd9;
        seqWrap = readFlag;
      end
    end else if (readFlag && cycInc == 6'd18) begin
      cycNext = 6'd9;
      seqWrap = 1'b1;
    end else if (isOne && cycInc == 6'd27) begin
      cycNext = 6'd18;
    end else if (cycInc == 6'd36) begin
      cycNext = 6'd27;
    end
  end

  // bit actions, decoded on the falling edge
  always_comb begin
    strobe = '0;
    strobe.seqAdv = sclRise && seqWrap;
    if (sclFall) begin
      if (isLegacy) begin
        if (cycCnt == 6'd9) begin
          strobe.writeBit = 1'b0;
        end else if (cycCnt > 6'd9) begin
          strobe.writeBit = !readFlag;
          strobe.pageAdv  = !readFlag && (cycCnt == 6'd17);
        end else if (cycCnt != 6'd0) begin
          strobe.shiftAddr = 1'b1;
        end
      end else begin
        if (ackCyc) begin
          strobe.writeBit = 1'b0;
        end else if (inData) begin
          strobe.writeBit = !readFlag;
          strobe.pageAdv  = !readFlag && ((cycCnt == 6'd26) || (cycCnt == 6'd35));
        end else if (cycCnt > 6'd9) begin
          strobe.shiftAddr = !readFlag;
          strobe.mergeDev  = !readFlag && isOne && (cycCnt == 6'd17);
        end else if (cycCnt != 6'd0) begin
          strobe.shiftDev = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started <= 1'b0;
      cycCnt  <= '0;
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclIn;
      prevSda <= sdaIn;
      if (startCond) begin
        started <= 1'b1;
        cycCnt  <= '0;
      end else if (stopCond) begin
        started <= 1'b0;
      end else if (sclRise) begin
        cycCnt <= cycNext;
      end
    end
  end

  assign bitSel = 6'd17 - cycCnt;

  always_comb begin
    sdaOut = prevSda;
    if (started) begin
      if (ackCyc) sdaOut = 1'b0;
      else if (readWin && readFlag) sdaOut = rdByte[bitSel[2:0]];
    end
  end
endmodule

// File: rtl/tws_data.sv
module tws_data
  import tws_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isLegacy,
  input  logic       isOne,
  input  twsStrobe_t strobe,
  input  logic       bitIn,
  output logic       readFlag,
  output logic [7:0] rdByte
);
  localparam int IDX_W = $clog2(MEM_BYTES);

  logic [3:0]        devReg;
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [IDX_W-1:0]  memIdx;
  logic [7:0]        mem [MEM_BYTES];

  assign readFlag = isLegacy ? addrReg[0] : devReg[0];
  assign memIdx   = isLegacy ? IDX_W'(addrReg[7:1]) : addrReg[IDX_W-1:0];
  assign rdByte   = mem[memIdx];

  always_comb begin
    addrNext = addrReg;
    if (strobe.shiftAddr) begin
      if (isLegacy)    addrNext = {5'b0, addrReg[6:0], bitIn};
      else if (isOne)  addrNext = {5'b0, addrReg[6:0], bitIn};
      else             addrNext = {addrReg[11:0], bitIn};
      if (strobe.mergeDev) addrNext = {2'b0, devReg[3:1], addrReg[6:0], bitIn};
    end
    if (strobe.pageAdv) begin
      if (isLegacy) addrNext = {addrReg[12:3], addrReg[2:1] + 2'd1, addrReg[0]};
      else          addrNext = {addrReg[12:4], addrReg[3:0] + 4'd1};
    end
    if (strobe.seqAdv) begin
      if (isLegacy) addrNext = {5'b0, addrReg[7:1] + 7'd1, addrReg[0]};
      else          addrNext = addrReg + 13'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devReg  <= '0;
      addrReg <= '0;
    end else begin
      if (strobe.shiftDev) devReg <= {devReg[2:0], bitIn};
      addrReg <= addrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeBit) mem[memIdx] <= {mem[memIdx][6:0], bitIn};
  end
endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom
  import tws_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOut
);
  twsStrobe_t       strobe;
  logic             isLegacy, isOne, readFlag;
  logic             started, prevScl, prevSda;
  logic [CYC_W-1:0] cycCnt;
  logic [7:0]       rdByte;

  assign isLegacy = (mode == 2'd0);
  assign isOne    = (mode == 2'd1);

  tws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .isLegacy(isLegacy), .isOne(isOne),
    .sclIn(sclIn), .sdaIn(sdaIn), .readFlag(readFlag), .rdByte(rdByte),
    .strobe(strobe), .started(started), .prevScl(prevScl), .prevSda(prevSda),
    .cycCnt(cycCnt), .sdaOut(sdaOut)
  );

  tws_data #(.MEM_BYTES(MEM_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .isLegacy(isLegacy), .isOne(isOne),
    .strobe(strobe), .bitIn(sdaIn), .readFlag(readFlag), .rdByte(rdByte)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             sclIn,
  input logic             sdaIn,
  input logic             sdaOut,
  input logic             started,
  input logic             prevScl,
  input logic             prevSda,
  input logic [CYC_W-1:0] cycCnt
);
  a_r2_start_seen: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && prevScl && prevSda && !sdaIn) |=> (started && cycCnt == 6'd0));

  a_r2_stop_seen: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && prevScl && !prevSda && sdaIn) |=> !started);

  a_r3_ack_low: assert property (@(posedge clk) disable iff (!rstN)
    (started && (cycCnt == 6'd9 || cycCnt == 6'd18 || cycCnt == 6'd27)) |-> !sdaOut);

  a_r4_legacy_range: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && started) |-> (cycCnt <= 6'd17));

  a_r7_one_range: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && started) |-> (cycCnt <= 6'd26));

  a_r8_two_range: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && started) |-> (cycCnt <= 6'd35));
endmodule

bind tws_eeprom tws_checker chk (
  .clk(clk), .rstN(rstN), .mode(mode), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaOut(sdaOut), .started(started), .prevScl(prevScl), .prevSda(prevSda),
  .cycCnt(cycCnt)
);

// File: tb/tb_tws_eeprom.sv
`timescale 1ns/1ps
module tb_tws_eeprom;
  localparam int MEM = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaOut;

  tws_eeprom #(.MEM_BYTES(MEM)) dut (
    .clk(clk), .rstN(rstN), .mode(mode), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOut(sdaOut)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] refMem [MEM];
  logic       known  [MEM];
  logic [7:0] dbuf   [32];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] legPageNext(input logic [6:0] w);
    return {w[6:2], w[1:0] + 2'd1};
  endfunction

  function automatic logic [12:0] stdPageNext(input logic [12:0] a);
    return {a[12:4], a[3:0] + 4'd1};
  endfunction

  function automatic int idxOf(input logic [12:0] a);
    return int'(a) % MEM;
  endfunction

  task automatic hold();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic startC();
    sclIn = 1'b0; hold();
    sdaIn = 1'b1; hold();
    sclIn = 1'b1; hold();
    sdaIn = 1'b0; hold();
    sclIn = 1'b0; hold();
  endtask

  task automatic stopC();
    sclIn = 1'b0; hold();
    sdaIn = 1'b0; hold();
    sclIn = 1'b1; hold();
    sdaIn = 1'b1; hold();
  endtask

  task automatic sendBit(input logic b);
    sdaIn = b;    hold();
    sclIn = 1'b1; hold();
    sclIn = 1'b0; hold();
  endtask

  task automatic clockRead(input logic drv, output logic got);
    sdaIn = drv;  hold();
    sclIn = 1'b1; hold();
    got = sdaOut;
    sclIn = 1'b0; hold();
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    clockRead(1'b1, a);
    check("R3 ack slot low", {15'b0, a}, 16'h0);
  endtask

  task automatic readByte(input logic drv, input logic ackBit, output logic [7:0] got);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      clockRead(drv, b);
      got[i] = b;
    end
    sendBit(ackBit);
  endtask

  task automatic legacyWrite(input logic [6:0] word, input int n);
    logic [6:0] w;
    w = word;
    startC();
    sendByte({word, 1'b0});
    for (int k = 0; k < n; k++) begin
      sendByte(dbuf[k]);
      refMem[w] = dbuf[k];
      known[w] = 1'b1;
      w = legPageNext(w);
    end
    stopC();
  endtask

  task automatic legacyRead(input logic [6:0] word, input int n, input logic drv, input string req);
    logic [6:0] w;
    logic [7:0] got;
    w = word;
    startC();
    sendByte({word, 1'b1});
    for (int k = 0; k < n; k++) begin
      readByte(drv, (k == n - 1), got);
      if (known[w]) check(req, {8'b0, got}, {8'b0, refMem[w]});
      w = w + 7'd1;
    end
    stopC();
  endtask

  task automatic stdHeader(input logic [1:0] m, input logic [12:0] addr);
    startC();
    sendByte({4'hA, (m == 2'd1) ? addr[10:8] : 3'b000, 1'b0});
    if (m != 2'd1) sendByte({3'b000, addr[12:8]});
    sendByte(addr[7:0]);
  endtask

  task automatic stdWrite(input logic [1:0] m, input logic [12:0] addr, input int n);
    logic [12:0] a;
    a = (m == 2'd1) ? {2'b00, addr[10:0]} : addr;
    stdHeader(m, addr);
    for (int k = 0; k < n; k++) begin
      sendByte(dbuf[k]);
      refMem[idxOf(a)] = dbuf[k];
      known[idxOf(a)] = 1'b1;
      a = stdPageNext(a);
    end
    stopC();
  endtask

  task automatic stdRead(input logic [1:0] m, input logic [12:0] addr, input int n, input string req);
    logic [12:0] a;
    logic [7:0] got;
    a = (m == 2'd1) ? {2'b00, addr[10:0]} : addr;
    stdHeader(m, addr);
    startC();
    sendByte({4'hA, (m == 2'd1) ? addr[10:8] : 3'b000, 1'b1});
    for (int k = 0; k < n; k++) begin
      readByte(1'b1, (k == n - 1), got);
      if (known[idxOf(a)]) check(req, {8'b0, got}, {8'b0, refMem[idxOf(a)]});
      a = a + 13'd1;
    end
    stopC();
  endtask

  task automatic fillBuf(input int n);
    for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom_range(0, 255));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd2024);
    for (int i = 0; i < MEM; i++) known[i] = 1'b0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    hold();

    // R1: idle after reset
    check("R1 reset sdaOut", {15'b0, sdaOut}, 16'h1);

    // R2: idle echo of the data line
    sclIn = 1'b0; hold();
    sdaIn = 1'b0; hold();
    check("R2 idle echo low", {15'b0, sdaOut}, 16'h0);
    sdaIn = 1'b1; hold();
    check("R2 idle echo high", {15'b0, sdaOut}, 16'h1);
    sclIn = 1'b1; hold();

    // legacy mode, directed page wrap and address wrap
    mode = 2'd0; hold();
    dbuf[0] = 8'h5A;
    legacyWrite(7'h00, 1);
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
    legacyWrite(7'h7E, 4);
    legacyRead(7'h7C, 4, 1'b1, "R5 legacy page wrap");
    legacyRead(7'h7F, 2, 1'b1, "R6 legacy address wrap");
    check("R4 legacy byte MSB first", {8'b0, refMem[7'h7E]}, 16'h0011);

    // R12: master drives low during a legacy read; storage must not change
    legacyRead(7'h7C, 2, 1'b0, "R11 read while master low");
    legacyRead(7'h7C, 4, 1'b1, "R12 read direction ignores data");

    for (int it = 0; it < 6; it++) begin
      logic [6:0] w;
      int n;
      w = 7'($urandom_range(0, 127));
      n = $urandom_range(1, 6);
      fillBuf(n);
      legacyWrite(w, n);
      legacyRead({w[6:2], 2'b00}, 5, 1'b1, "R5 legacy random page");
    end

    // one-byte-address mode
    mode = 2'd1; hold();
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    stdWrite(2'd1, 13'h05FE, 3);
    stdRead(2'd1, 13'h05F0, 1, "R9 one-byte page wrap");
    stdRead(2'd1, 13'h05FE, 2, "R7 device bits extend address");
    dbuf[0] = 8'h7E;
    stdWrite(2'd1, 13'h07FF, 1);
    dbuf[0] = 8'h81;
    stdWrite(2'd1, 13'h0000, 1);
    stdRead(2'd1, 13'h07FF, 2, "R10 one-byte sequential wrap");
    for (int it = 0; it < 6; it++) begin
      logic [12:0] a;
      int n;
      a = 13'($urandom_range(0, 2047));
      n = $urandom_range(1, 18);
      fillBuf(n);
      stdWrite(2'd1, a, n);
      stdRead(2'd1, {a[12:4], 4'h0}, 16, "R11 one-byte random read");
    end

    // two-byte-address mode
    mode = 2'd2; hold();
    dbuf[0] = 8'h3C; dbuf[1] = 8'hC3; dbuf[2] = 8'h96;
    stdWrite(2'd2, 13'h1FFE, 3);
    stdRead(2'd2, 13'h1FF0, 1, "R9 two-byte page wrap");
    dbuf[0] = 8'h42;
    stdWrite(2'd2, 13'h0000, 1);
    stdRead(2'd2, 13'h1FFF, 2, "R10 two-byte address wrap");
    for (int it = 0; it < 6; it++) begin
      logic [12:0] a;
      int n;
      a = 13'($urandom_range(0, 8191));
      n = $urandom_range(1, 18);
      fillBuf(n);
      stdWrite(2'd2, a, n);
      stdRead(2'd2, {a[12:4], 4'h0}, 16, "R8 two-byte random read");
    end

    check("R2 idle after stop", {15'b0, sdaOut}, 16'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule